// File: doc/BRIEF.md
# SDRAM Burst Reordering Arbiter

This block keeps a small pool of SDRAM burst operations that are waiting to be issued and chooses at most one of them to go to the command sequencer in each cycle. Each pooled operation holds a chip select, bank, row, column, a read/write flag and a priority. Arbitration of arrival order uses an age relation that is recorded when each operation is written in. Selection has two stages. In the first stage an operation is filtered for eligibility. Its slot's timer-ready flag, which external DRAM timing counters drive, must be set. It must not be held behind an earlier operation to the same open page. It must not be yielding to a high-priority operation that holds its bank. In the second stage the eligible operations compete by priority, then by read before write, then by age.

High-priority operations have a priority at or above a threshold parameter. Such an operation gets special treatment. If its bank is idle and nothing earlier touches the same chip select, row and column, it takes the grant at once, ahead of every other candidate. If its bank is busy, ordinary operations to that bank stand back until it has been issued. If an earlier operation matches its chip select, row and column, the high-priority operation waits until that earlier one has gone. The grant has no register between the pool and the output. The selected slot is issued and removed at the next clock edge.

Top module: `sdq_reorder_arb`

## Requirements
- R1: After reset the pool is empty, `issue_valid` is low and `enq_ready` is high.
- R2: An accepted operation is written into the lowest-numbered free slot. `enq_ready` is low exactly when all DEPTH slots hold operations. An `enq_valid` that arrives while `enq_ready` is low has no effect on the pool.
- R3: An operation is issued only in a cycle where bit `timer_ok[slot]` of its slot is high.
- R4: Among competing operations, the one with the numerically larger priority is issued first.
- R5: When the priorities are equal, a read (`is_read`=1) is issued before a write.
- R6: When priority and direction are both equal, the operation that was accepted earliest is issued first.
- R7: Operations with the same chip select, bank and row are issued in the order in which they were accepted. A younger operation to that page stays ineligible while an older one is pending.
- R8: Consider a high-priority operation (priority >= HP_PRIO) whose timer is ready and whose bank is idle. Its bank is indexed as `bank_idle[{cs,bank}]`. It has no older pending operation that matches its chip select, row and column, and none to the same page. Such an operation is issued ahead of every operation that does not meet these conditions, including high-priority operations with a higher priority.
- R9: Suppose a pending high-priority operation targets a busy bank and is not held by R7 or R10. Then no lower-priority operation to that chip select and bank is issued, even if its timer is ready.
- R10: A high-priority operation is not issued while an older pending operation matches its chip select, row and column, in any bank.
- R11: At most one operation is issued per cycle, and the issued operation leaves the pool at the next edge. `issue_valid` is high in every cycle where at least one operation is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer of a new operation |
| enq_ready | output | 1 | Pool has a free slot |
| enq_cs | input | CS_W | Chip select of the new operation |
| enq_bank | input | BANK_W | Bank of the new operation |
| enq_row | input | ROW_W | Row of the new operation |
| enq_col | input | COL_W | Column of the new operation |
| enq_is_read | input | 1 | 1 for read, 0 for write |
| enq_prio | input | PRIO_W | Priority, larger is more urgent |
| timer_ok | input | DEPTH | Per-slot timing-satisfied flags |
| bank_idle | input | 2**(CS_W+BANK_W) | Per chip-select/bank idle flags |
| issue_valid | output | 1 | A slot is granted and dequeued this cycle |
| issue_idx | output | IDX_W | Granted slot number |
| issue_cs | output | CS_W | Chip select of the granted operation |
| issue_bank | output | BANK_W | Bank of the granted operation |
| issue_row | output | ROW_W | Row of the granted operation |
| issue_col | output | COL_W | Column of the granted operation |
| issue_is_read | output | 1 | Direction of the granted operation |
| issue_prio | output | PRIO_W | Priority of the granted operation |

## Verification
The bench builds the arbiter with a pool depth of 4 and a high-priority threshold of 6. A depth of 4 makes the full-pool back-pressure reachable after four offers. It also means that a random stream regularly packs the pool with page conflicts, column hazards and bank guards at the same moment. A threshold of 6 leaves two high-priority levels. This lets the bench pit a bypassing priority-6 operation against a priority-7 operation on a busy bank. The address fields are drawn from narrow ranges so that same-page and same-column collisions occur often.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int CS_W   = 1;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 10;
    localparam int PRIO_W = 3;
    localparam int SLOT_W = CS_W + BANK_W;
    localparam int NBANK  = 1 << SLOT_W;

    typedef struct packed {
        logic [CS_W-1:0]   cs;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } sdq_addr_t;

    typedef struct packed {
        sdq_addr_t         addr;
        logic              is_read;
        logic [PRIO_W-1:0] prio;
    } sdq_op_t;

    function automatic logic same_page(sdq_addr_t a, sdq_addr_t b);
        return (a.cs == b.cs) && (a.bank == b.bank) && (a.row == b.row);
    endfunction

    function automatic logic same_cell(sdq_addr_t a, sdq_addr_t b);
        return (a.cs == b.cs) && (a.row == b.row) && (a.col == b.col);
    endfunction

    function automatic logic [SLOT_W-1:0] bank_slot(sdq_addr_t a);
        return {a.cs, a.bank};
    endfunction

    // a outranks b: priority, then read over write, then age
    function automatic logic outranks(logic [PRIO_W-1:0] pa, logic ra,
                                      logic [PRIO_W-1:0] pb, logic rb,
                                      logic a_older);
        if (pa != pb) return pa > pb;
        if (ra != rb) return ra;
        return a_older;
    endfunction

endpackage

// File: rtl/sdq_pool.sv
module sdq_pool import sdq_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid_i,
    input  sdq_op_t          enq_op_i,
    input  logic             deq_valid_i,
    input  logic [IDX_W-1:0] deq_idx_i,
    output logic [DEPTH-1:0] valid_o,
    output sdq_op_t          ops_o   [DEPTH],
    output logic [DEPTH-1:0] older_o [DEPTH],
    output logic             full_o
);

    logic [DEPTH-1:0] valid_q;
    sdq_op_t          ops_q   [DEPTH];
    logic [DEPTH-1:0] older_q [DEPTH];   // older_q[i][j]: slot i entered before slot j
    logic             free_hit;
    logic [IDX_W-1:0] free_idx;
    logic             do_enq;

    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign do_enq = enq_valid_i && free_hit;
    assign full_o = !free_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else begin
            if (deq_valid_i) valid_q[deq_idx_i] <= 1'b0;
            if (do_enq) begin
                valid_q[free_idx] <= 1'b1;
                ops_q[free_idx]   <= enq_op_i;
                older_q[free_idx] <= '0;
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != int'(free_idx)) older_q[j][free_idx] <= valid_q[j];
                end
            end
        end
    end

    assign valid_o = valid_q;
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ops_o[i]   = ops_q[i];
            older_o[i] = older_q[i];
        end
    end

    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (enq_valid_i && !free_hit && !deq_valid_i) |=> $stable(valid_q)); // R2
    AST_DEQ_LIVE_SLOT: assert property (@(posedge clk) disable iff (rst)
        deq_valid_i |-> valid_q[deq_idx_i]); // R11
    AST_DEQ_LEAVES: assert property (@(posedge clk) disable iff (rst)
        deq_valid_i |=> !valid_q[$past(deq_idx_i)]); // R11

endmodule

// File: rtl/sdq_hazard.sv
module sdq_hazard import sdq_pkg::*; #(
    parameter int DEPTH   = 8,
    parameter int HP_PRIO = 6
) (
    input  logic [DEPTH-1:0]  valid_i,
    input  sdq_addr_t         addr_i   [DEPTH],
    input  logic [PRIO_W-1:0] prio_i   [DEPTH],
    input  logic [DEPTH-1:0]  older_i  [DEPTH],
    input  logic [DEPTH-1:0]  timer_ok_i,
    input  logic [NBANK-1:0]  bank_idle_i,
    output logic [DEPTH-1:0]  elig_o,
    output logic [DEPTH-1:0]  bypass_o
);

    logic [DEPTH-1:0] hp;
    logic [DEPTH-1:0] page_blk;
    logic [DEPTH-1:0] cell_blk;
    logic [DEPTH-1:0] guard;
    logic [DEPTH-1:0] yield_b;
    logic [DEPTH-1:0] idle_b;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign hp[i]     = valid_i[i] && (int'(prio_i[i]) >= HP_PRIO);
        assign idle_b[i] = bank_idle_i[bank_slot(addr_i[i])];

        always_comb begin
            page_blk[i] = 1'b0;
            cell_blk[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && valid_i[j] && older_i[j][i]) begin
                    if (same_page(addr_i[j], addr_i[i])) page_blk[i] = 1'b1;
                    if (same_cell(addr_i[j], addr_i[i])) cell_blk[i] = 1'b1;
                end
            end
        end

        // an unstalled high-priority op holds its busy bank
        assign guard[i] = hp[i] && !page_blk[i] && !cell_blk[i] && !idle_b[i];

        always_comb begin
            yield_b[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && guard[j] &&
                    bank_slot(addr_i[j]) == bank_slot(addr_i[i]))
                    yield_b[i] = 1'b1;
            end
        end

        assign elig_o[i] = valid_i[i] && timer_ok_i[i] && !page_blk[i] &&
                           !(hp[i] && cell_blk[i]) && !(!hp[i] && yield_b[i]);
        assign bypass_o[i] = elig_o[i] && hp[i] && idle_b[i];
    end

endmodule

// File: rtl/sdq_pick.sv
module sdq_pick import sdq_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEPTH-1:0]  elig_i,
    input  logic [DEPTH-1:0]  bypass_i,
    input  logic [PRIO_W-1:0] prio_i  [DEPTH],
    input  logic [DEPTH-1:0]  rd_i,
    input  logic [DEPTH-1:0]  older_i [DEPTH],
    output logic              win_valid_o,
    output logic [IDX_W-1:0]  win_idx_o
);

    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] win;

    assign cand = (|bypass_i) ? bypass_i : elig_i;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        always_comb begin
            win[i] = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand[j] &&
                    !outranks(prio_i[i], rd_i[i], prio_i[j], rd_i[j], older_i[i][j]))
                    win[i] = 1'b0;
            end
        end
    end

    always_comb begin
        win_idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win[i]) win_idx_o = IDX_W'(i);
        end
    end
    assign win_valid_o = |win;

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win)); // R11
    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (rst)
        (|elig_i) |-> win_valid_o); // R11
    AST_BYPASS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|bypass_i) |-> bypass_i[win_idx_o]); // R8

endmodule

// File: rtl/sdq_reorder_arb.sv
module sdq_reorder_arb import sdq_pkg::*; #(
    parameter int DEPTH   = 8,
    parameter int HP_PRIO = 6,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [CS_W-1:0]   enq_cs,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [COL_W-1:0]  enq_col,
    input  logic              enq_is_read,
    input  logic [PRIO_W-1:0] enq_prio,
    input  logic [DEPTH-1:0]  timer_ok,
    input  logic [NBANK-1:0]  bank_idle,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [CS_W-1:0]   issue_cs,
    output logic [BANK_W-1:0] issue_bank,
    output logic [ROW_W-1:0]  issue_row,
    output logic [COL_W-1:0]  issue_col,
    output logic              issue_is_read,
    output logic [PRIO_W-1:0] issue_prio
);

    sdq_op_t           enq_op;
    logic [DEPTH-1:0]  valid;
    sdq_op_t           ops    [DEPTH];
    logic [DEPTH-1:0]  older  [DEPTH];
    sdq_addr_t         addrs  [DEPTH];
    logic [PRIO_W-1:0] prios  [DEPTH];
    logic [DEPTH-1:0]  rds;
    logic [DEPTH-1:0]  elig;
    logic [DEPTH-1:0]  bypass;
    logic              full;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    sdq_op_t           sel;

    assign enq_op = '{addr: '{cs: enq_cs, bank: enq_bank, row: enq_row, col: enq_col},
                      is_read: enq_is_read, prio: enq_prio};

    sdq_pool #(.DEPTH(DEPTH)) u_pool (
        .clk(clk), .rst(rst),
        .enq_valid_i(enq_valid), .enq_op_i(enq_op),
        .deq_valid_i(win_valid), .deq_idx_i(win_idx),
        .valid_o(valid), .ops_o(ops), .older_o(older), .full_o(full)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            addrs[i] = ops[i].addr;
            prios[i] = ops[i].prio;
            rds[i]   = ops[i].is_read;
        end
    end

    sdq_hazard #(.DEPTH(DEPTH), .HP_PRIO(HP_PRIO)) u_hazard (
        .valid_i(valid), .addr_i(addrs), .prio_i(prios), .older_i(older),
        .timer_ok_i(timer_ok), .bank_idle_i(bank_idle),
        .elig_o(elig), .bypass_o(bypass)
    );

    sdq_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst(rst),
        .elig_i(elig), .bypass_i(bypass), .prio_i(prios), .rd_i(rds),
        .older_i(older), .win_valid_o(win_valid), .win_idx_o(win_idx)
    );

    assign sel           = ops[win_idx];
    assign enq_ready     = !full;
    assign issue_valid   = win_valid;
    assign issue_idx     = win_idx;
    assign issue_cs      = sel.addr.cs;
    assign issue_bank    = sel.addr.bank;
    assign issue_row     = sel.addr.row;
    assign issue_col     = sel.addr.col;
    assign issue_is_read = sel.is_read;
    assign issue_prio    = sel.prio;

    AST_TIMER_GATE: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> timer_ok[issue_idx]); // R3

endmodule

// File: tb/tb_sdq_reorder_arb.sv
module tb_sdq_reorder_arb;
    import sdq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 4;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 1'b0;
    logic enq_ready;
    logic [CS_W-1:0]   enq_cs = '0;
    logic [BANK_W-1:0] enq_bank = '0;
    logic [ROW_W-1:0]  enq_row = '0;
    logic [COL_W-1:0]  enq_col = '0;
    logic enq_is_read = 1'b0;
    logic [PRIO_W-1:0] enq_prio = '0;
    logic [D-1:0]     timer_ok = '0;
    logic [NBANK-1:0] bank_idle = '1;
    logic issue_valid;
    logic [1:0] issue_idx;
    logic [CS_W-1:0]   issue_cs;
    logic [BANK_W-1:0] issue_bank;
    logic [ROW_W-1:0]  issue_row;
    logic [COL_W-1:0]  issue_col;
    logic issue_is_read;
    logic [PRIO_W-1:0] issue_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model
    bit m_v[D];
    int m_cs[D], m_bk[D], m_row[D], m_col[D], m_rd[D], m_pr[D], m_seq[D];
    int seq_ctr = 0;

    sdq_reorder_arb #(.DEPTH(D), .HP_PRIO(HP)) dut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_cs(enq_cs), .enq_bank(enq_bank), .enq_row(enq_row), .enq_col(enq_col),
        .enq_is_read(enq_is_read), .enq_prio(enq_prio), .timer_ok(timer_ok),
        .bank_idle(bank_idle), .issue_valid(issue_valid), .issue_idx(issue_idx),
        .issue_cs(issue_cs), .issue_bank(issue_bank), .issue_row(issue_row),
        .issue_col(issue_col), .issue_is_read(issue_is_read), .issue_prio(issue_prio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic ck(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit is_older(int a, int b);
        return m_seq[a] < m_seq[b];
    endfunction

    function automatic bit held(int i);       // same-page or same-cell hold on slot i
        for (int j = 0; j < D; j++)
            if (j != i && m_v[j] && is_older(j, i) && m_cs[j] == m_cs[i] &&
                ((m_bk[j] == m_bk[i] && m_row[j] == m_row[i]) ||
                 (m_pr[i] >= HP && m_row[j] == m_row[i] && m_col[j] == m_col[i])))
                return 1;
        return 0;
    endfunction

    function automatic int model_pick();
        bit el[D], by[D], any_by;
        int best;
        any_by = 0;
        for (int i = 0; i < D; i++) begin
            bit yl;
            bit idle;
            idle = bank_idle[m_cs[i]*4 + m_bk[i]];
            yl = 0;
            for (int j = 0; j < D; j++)
                if (j != i && m_v[j] && m_pr[j] >= HP && !held(j) &&
                    !bank_idle[m_cs[j]*4 + m_bk[j]] &&
                    m_cs[j] == m_cs[i] && m_bk[j] == m_bk[i]) yl = 1;
            el[i] = m_v[i] && timer_ok[i] && !held(i) && !(m_pr[i] < HP && yl);
            by[i] = el[i] && m_pr[i] >= HP && idle;
            if (by[i]) any_by = 1;
        end
        best = -1;
        for (int i = 0; i < D; i++) begin
            if (any_by ? by[i] : el[i]) begin
                if (best < 0) best = i;
                else if (m_pr[i] > m_pr[best]) best = i;
                else if (m_pr[i] == m_pr[best] && m_rd[i] > m_rd[best]) best = i;
                else if (m_pr[i] == m_pr[best] && m_rd[i] == m_rd[best] && is_older(i, best)) best = i;
            end
        end
        return best;
    endfunction

    // inputs are set at a falling edge; compare, then advance the model over the next rising edge
    task automatic step(string tag);
        int exp_i, free;
        bit exp_r;
        #1;
        exp_i = model_pick();
        free = -1;
        for (int i = D - 1; i >= 0; i--) if (!m_v[i]) free = i;
        exp_r = (free >= 0);
        ck(issue_valid == (exp_i >= 0), tag, "issue_valid", int'(issue_valid), int'(exp_i >= 0));
        ck(enq_ready == exp_r, tag, "enq_ready", int'(enq_ready), int'(exp_r));
        if (exp_i >= 0 && issue_valid) begin
            ck(int'(issue_idx) == exp_i, tag, "issue_idx", int'(issue_idx), exp_i);
            ck(int'(issue_row) == m_row[exp_i], tag, "issue_row", int'(issue_row), m_row[exp_i]);
        end
        if (enq_valid && exp_r) begin
            m_v[free] = 1; m_cs[free] = int'(enq_cs); m_bk[free] = int'(enq_bank);
            m_row[free] = int'(enq_row); m_col[free] = int'(enq_col);
            m_rd[free] = int'(enq_is_read); m_pr[free] = int'(enq_prio);
            m_seq[free] = seq_ctr++;
        end
        if (exp_i >= 0) m_v[exp_i] = 0;
        @(negedge clk);
    endtask

    task automatic put(int cs, int bk, int row, int col, int rd, int pr, string tag);
        enq_valid = 1; enq_cs = CS_W'(cs); enq_bank = BANK_W'(bk);
        enq_row = ROW_W'(row); enq_col = COL_W'(col);
        enq_is_read = rd[0]; enq_prio = PRIO_W'(pr);
        step(tag);
        enq_valid = 0;
    endtask

    task automatic drain(string tag);
        timer_ok = '1; bank_idle = '1;
        for (int k = 0; k < 12; k++) step(tag);
        timer_ok = '0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty after reset
        step("R1");
        step("R1");
        // R2: fill, offer into full pool, then drain
        put(0, 0, 1, 1, 0, 1, "R2"); put(0, 1, 2, 2, 0, 1, "R2");
        put(0, 2, 3, 3, 0, 1, "R2"); put(0, 3, 4, 4, 0, 1, "R2");
        put(1, 0, 5, 5, 1, 7, "R2"); put(1, 1, 6, 6, 1, 7, "R2");
        drain("R2");
        // R3: only the slot whose timer is ready goes
        put(0, 0, 1, 1, 1, 3, "R3"); put(0, 1, 2, 2, 1, 3, "R3");
        timer_ok = 4'b0010; step("R3"); step("R3");
        drain("R3");
        // R4: priority order
        put(0, 0, 1, 1, 0, 1, "R4"); put(0, 1, 2, 2, 0, 4, "R4"); put(0, 2, 3, 3, 0, 3, "R4");
        drain("R4");
        // R5: read before write at equal priority
        put(0, 0, 1, 1, 0, 2, "R5"); put(0, 1, 2, 2, 1, 2, "R5");
        drain("R5");
        // R6: oldest first
        put(0, 3, 1, 1, 1, 2, "R6"); put(0, 1, 2, 2, 1, 2, "R6"); put(0, 2, 3, 3, 1, 2, "R6");
        drain("R6");
        // R7: same page keeps arrival order despite higher priority and read
        put(0, 1, 9, 1, 0, 0, "R7"); put(0, 1, 9, 2, 1, 5, "R7"); put(0, 2, 8, 3, 0, 1, "R7");
        drain("R7");
        // R8: bypass on idle bank beats priority 7 on a busy bank
        put(0, 0, 1, 1, 0, 6, "R8"); put(0, 1, 2, 2, 1, 7, "R8"); put(0, 2, 3, 3, 1, 5, "R8");
        timer_ok = '1; bank_idle = 8'b1111_1101;
        step("R8"); step("R8"); step("R8"); step("R8");
        drain("R8");
        // R9: lower-priority op on a guarded busy bank stands back
        put(0, 1, 1, 1, 0, 7, "R9"); put(0, 1, 2, 2, 1, 5, "R9"); put(0, 2, 3, 3, 0, 1, "R9");
        bank_idle = 8'b1111_1101; timer_ok = 4'b0110;
        step("R9"); step("R9"); step("R9");
        timer_ok = '1; step("R9"); step("R9"); step("R9");
        drain("R9");
        // R10: high-priority op waits for an older same-cell op in another bank
        put(0, 0, 5, 3, 0, 1, "R10"); put(0, 2, 5, 3, 1, 7, "R10"); put(0, 3, 6, 4, 0, 0, "R10");
        timer_ok = 4'b0110; step("R10"); step("R10"); step("R10");
        timer_ok = '1; step("R10"); step("R10");
        drain("R10");
        // R11: random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            enq_valid = $urandom_range(0, 1) == 1;
            enq_cs = CS_W'($urandom_range(0, 1)); enq_bank = BANK_W'($urandom_range(0, 3));
            enq_row = ROW_W'($urandom_range(0, 3)); enq_col = COL_W'($urandom_range(0, 3));
            enq_is_read = $urandom_range(0, 1) == 1; enq_prio = PRIO_W'($urandom_range(0, 7));
            timer_ok = D'($urandom_range(0, 15));
            bank_idle = NBANK'($urandom_range(0, 255));
            step("R11");
        end
        enq_valid = 0;
        drain("R11");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule